// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block runs on the master clock of a serial audio port and divides it down into a bit clock and a frame clock. The frame clock is a left/right select in two-channel mode or a one-bit-wide frame sync in multi-slot mode. Software-side logic presents a configuration and strobes it in:

- a sample-rate family bit,
- the master-clock-to-sample-rate ratio,
- the slot width,
- the number of slots per frame,
- the framing mode.

The block works out the divider from the frame geometry: master clocks per frame divided by (slot width × slot count). It rejects any combination that does not give a whole, even divider of at least two.

A new configuration never takes effect in the middle of a frame. After a change is requested, the running clocks complete their current bit-clock high phase. Both outputs are then held low until the current frame ends. The new setting starts cleanly at the next frame start. This means that neither a shortened bit-clock pulse nor a period belonging to an unsupported ratio can reach the pins.

A rejected setting raises an error flag at that frame boundary, and the previous setting carries on. Strobing in a configuration identical to the active one, family bit included, leaves the running clocks untouched.

Top module: `audio_sclk_gen`

## Requirements
- R1: While reset is asserted, and after its release until a first valid configuration has been applied, `bclk`, `lrck` and `config_error` are all low.
- R2: The ratio code selects 256 (code 0), 384 (code 1) or 512 (code 2) master clocks per frame. The width code selects 16 (code 0), 24 (code 1) or 32 (code 2) bits per slot. `bclk` has a period of ratio/(width × slots) master clocks, with its high phase exactly half of that period.
- R3: The divider follows these example settings:
  - 256fs, 32-bit stereo: divide by 4 (3.072 MHz from 12.288 MHz, or 2.8224 MHz from 11.2896 MHz).
  - 512fs, 32-bit, 8 slots: divide by 2 (12.288 MHz from 24.576 MHz).
  - 256fs, 16-bit stereo: divide by 8, which halves the bit clock.
- R4: `lrck` has exactly one rising edge per frame, where a frame is ratio master clocks.
- R5: In two-channel mode (`cfg_tdm`=0), `lrck` is low for the first slot-width bit clocks of each frame and high for the rest. It changes only where `bclk` falls, one bit clock ahead of the first data bit of each channel.
- R6: In multi-slot mode (`cfg_tdm`=1), `lrck` is a pulse one bit clock wide at the start of each frame, rising together with a `bclk` falling edge.
- R7: After a changed configuration is strobed, the outputs finish the current `bclk` high phase. They are then low until the current frame ends, and the new setting begins at the next frame start. Every `bclk` high phase has the length of either the old or the new setting.
- R8: Strobing a configuration equal to the active one, family bit included, does not interrupt or shift `bclk` or `lrck`.
- R9: The setting is rejected at the frame boundary, `config_error` is raised, and the previous setting continues if any of the following holds:
  - ratio code 3,
  - width code 3,
  - fewer than 2 or more than 16 slots,
  - two-channel mode with a slot count other than 2,
  - a divider that is not a whole even number of at least 2.

  The next accepted setting clears `config_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | One-cycle strobe that requests the configuration on the cfg_* inputs |
| cfg_family | input | 1 | Sample-rate family: 0 = 44.1 kHz root, 1 = 48 kHz root |
| cfg_ratio | input | 2 | Master clocks per frame: 0 = 256, 1 = 384, 2 = 512 |
| cfg_width | input | 2 | Bits per slot: 0 = 16, 1 = 24, 2 = 32 |
| cfg_slots | input | 5 | Slots per frame, 2 to 16 |
| cfg_tdm | input | 1 | 0 = two-channel framing, 1 = multi-slot framing with sync pulse |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Channel select or frame sync |
| config_error | output | 1 | Last attempted configuration was rejected |

## Verification
A divider or bit counter that holds a wrong value shows up within one frame as a wrong count of `bclk` rising edges, or as a wrong `lrck` high time, over a two-frame window. A frame-boundary detector that fires at the wrong time shows up on the first switch. Either the quiet gap before the new clocks differs from the cycles left in the frame, or a `bclk` high phase matches neither the old nor the new divider. A comparison of the strobed configuration against the active one that misses a difference, or is too loose, shows up as an identical reload that loses bit-clock edges. A validity decode that goes wrong shows up as `config_error` disagreeing with the table of legal combinations, one frame after the strobe.

// File: rtl/audio_sclk_pkg.sv
package audio_sclk_pkg;

    parameter int unsigned MAX_SLOTS = 16;
    parameter int unsigned MAX_DIV   = 16;
    parameter int unsigned MAX_WIDTH = 32;

    localparam int unsigned MAX_BITS = MAX_WIDTH * MAX_SLOTS;
    localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS + 1);
    localparam int unsigned DIV_W    = $clog2(MAX_DIV + 1);
    localparam int unsigned BIT_W    = $clog2(MAX_BITS + 1);

    typedef struct packed {
        logic              family;
        logic [1:0]        ratio;
        logic [1:0]        width;
        logic [SLOT_W-1:0] slots;
        logic              tdm;
    } sclk_cfg_t;

    typedef struct packed {
        logic             run;
        logic             pend;
        logic             hold;
        logic             err;
        sclk_cfg_t        act;
        sclk_cfg_t        pcfg;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bits;
        logic             tdm;
        logic [DIV_W-1:0] dcnt;
        logic [BIT_W-1:0] bcnt;
    } sclk_state_t;

endpackage

// File: rtl/audio_sclk_cfg_check.sv
module audio_sclk_cfg_check
    import audio_sclk_pkg::*;
(
    input  sclk_cfg_t        cfg_i,
    output logic             ok_o,
    output logic [DIV_W-1:0] div_o,
    output logic [BIT_W-1:0] bits_o
);

    logic [BIT_W:0]   prod;
    logic [BIT_W:0]   rval;
    logic [5:0]       wval;
    logic [DIV_W-1:0] div_v;

    always_comb begin
        case (cfg_i.ratio)
            2'd0:    rval = (BIT_W+1)'(256);
            2'd1:    rval = (BIT_W+1)'(384);
            2'd2:    rval = (BIT_W+1)'(512);
            default: rval = '0;
        endcase
        case (cfg_i.width)
            2'd0:    wval = 6'd16;
            2'd1:    wval = 6'd24;
            2'd2:    wval = 6'd32;
            default: wval = 6'd0;
        endcase
        prod  = (BIT_W+1)'(wval) * (BIT_W+1)'(cfg_i.slots);
        div_v = '0;
        // search the legal even dividers instead of a general divide
        for (int d = 2; d <= int'(MAX_DIV); d += 2) begin
            if (d * int'(prod) == int'(rval)) div_v = DIV_W'(d);
        end
        ok_o = (rval != '0) && (wval != 6'd0)
            && (cfg_i.slots >= SLOT_W'(2))
            && (cfg_i.slots <= SLOT_W'(MAX_SLOTS))
            && (cfg_i.tdm || cfg_i.slots == SLOT_W'(2))
            && (div_v != '0);
        div_o  = div_v;
        bits_o = prod[BIT_W-1:0];
    end

endmodule

// File: rtl/audio_sclk_shape.sv
module audio_sclk_shape
    import audio_sclk_pkg::*;
(
    input  logic             gate_i,
    input  logic             tdm_i,
    input  logic [DIV_W-1:0] dcnt_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [BIT_W-1:0] bcnt_i,
    input  logic [BIT_W-1:0] bits_i,
    output logic             bclk_o,
    output logic             lrck_o
);

    always_comb begin
        // low half first, so the bit clock falls where the counters wrap
        bclk_o = gate_i && (dcnt_i >= (div_i >> 1));
        if (tdm_i) lrck_o = gate_i && (bcnt_i == '0);
        else       lrck_o = gate_i && (bcnt_i >= (bits_i >> 1));
    end

endmodule

// File: rtl/audio_sclk_gen.sv
module audio_sclk_gen
    import audio_sclk_pkg::*;
(
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_family,
    input  logic [1:0]        cfg_ratio,
    input  logic [1:0]        cfg_width,
    input  logic [SLOT_W-1:0] cfg_slots,
    input  logic              cfg_tdm,
    output logic              bclk,
    output logic              lrck,
    output logic              config_error
);

    sclk_state_t      s_d, s_q;
    sclk_cfg_t        in_cfg;
    logic             chk_ok;
    logic [DIV_W-1:0] chk_div;
    logic [BIT_W-1:0] chk_bits;
    logic             last_tick, frame_end, apply, gate;
    logic             bclk_d, bclk_q, lrck_d, lrck_q;

    assign in_cfg = '{family: cfg_family, ratio: cfg_ratio, width: cfg_width,
                      slots: cfg_slots, tdm: cfg_tdm};

    audio_sclk_cfg_check chk_i (
        .cfg_i  (s_q.pcfg),
        .ok_o   (chk_ok),
        .div_o  (chk_div),
        .bits_o (chk_bits)
    );

    always_comb begin
        s_d       = s_q;
        last_tick = (s_q.dcnt == s_q.div - DIV_W'(1));
        frame_end = s_q.run && last_tick && (s_q.bcnt == s_q.bits - BIT_W'(1));
        apply     = s_q.pend && (!s_q.run || frame_end);

        if (s_q.run) begin
            if (last_tick) begin
                s_d.dcnt = '0;
                s_d.bcnt = (s_q.bcnt == s_q.bits - BIT_W'(1)) ? '0
                                                               : s_q.bcnt + BIT_W'(1);
            end else begin
                s_d.dcnt = s_q.dcnt + DIV_W'(1);
            end
        end

        if (apply) begin
            s_d.pend = 1'b0;
            s_d.hold = 1'b0;
            if (chk_ok) begin
                s_d.run  = 1'b1;
                s_d.err  = 1'b0;
                s_d.act  = s_q.pcfg;
                s_d.div  = chk_div;
                s_d.bits = chk_bits;
                s_d.tdm  = s_q.pcfg.tdm;
                s_d.dcnt = '0;
                s_d.bcnt = '0;
            end else begin
                s_d.err  = 1'b1;
            end
        end

        if (cfg_load && !(s_q.run && !s_q.pend && in_cfg == s_q.act)) begin
            s_d.pend = 1'b1;
            s_d.pcfg = in_cfg;
        end

        // mute only from a bit-clock falling point, never mid high phase
        if (s_d.run && s_d.pend && s_d.dcnt == '0) s_d.hold = 1'b1;

        gate = s_d.run && !s_d.hold;
    end

    audio_sclk_shape shape_i (
        .gate_i (gate),
        .tdm_i  (s_d.tdm),
        .dcnt_i (s_d.dcnt),
        .div_i  (s_d.div),
        .bcnt_i (s_d.bcnt),
        .bits_i (s_d.bits),
        .bclk_o (bclk_d),
        .lrck_o (lrck_d)
    );

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            bclk_q <= 1'b0;
            lrck_q <= 1'b0;
        end else begin
            s_q    <= s_d;
            bclk_q <= bclk_d;
            lrck_q <= lrck_d;
        end
    end

    assign bclk         = bclk_q;
    assign lrck         = lrck_q;
    assign config_error = s_q.err;

    assert_hold_quiet_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        s_q.hold |-> (!bclk_q && !lrck_q));

    assert_idle_quiet_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        !s_q.run |-> (!bclk_q && !lrck_q));

    assert_div_legal_R2: assert property (@(posedge mclk) disable iff (!rst_n)
        s_q.run |-> (s_q.div >= DIV_W'(2) && !s_q.div[0]));

    assert_cnt_bound_R4: assert property (@(posedge mclk) disable iff (!rst_n)
        s_q.run |-> (s_q.dcnt < s_q.div && s_q.bcnt < s_q.bits));

    assert_err_at_apply_R9: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(s_q.err) |-> $past(s_q.pend));

    assert_sync_on_fall_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        (s_q.tdm && $rose(lrck_q)) |-> !bclk_q);

endmodule

// File: tb/audio_sclk_gen_tb_top.sv
module audio_sclk_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int NVEC       = 13;

    typedef struct packed {
        int r; int w; int n; int tdm; int fam; int ok; int d; int rlen;
    } vec_t;

    // ratio code, width code, slots, tdm, family, accepted, divider, mclk per frame
    localparam vec_t VEC [NVEC] = '{
        '{0, 2,  2, 0, 1, 1, 4, 256},
        '{2, 2,  8, 1, 1, 1, 2, 512},
        '{0, 2,  2, 0, 0, 1, 4, 256},
        '{0, 0,  2, 0, 0, 1, 8, 256},
        '{1, 1,  2, 0, 1, 1, 8, 384},
        '{1, 0,  4, 1, 1, 1, 6, 384},
        '{0, 1,  2, 0, 1, 0, 0, 0},
        '{2, 2,  4, 0, 1, 0, 0, 0},
        '{2, 0, 16, 1, 0, 1, 2, 512},
        '{3, 2,  2, 0, 1, 0, 0, 0},
        '{0, 2,  8, 1, 1, 0, 0, 0},
        '{2, 1, 16, 1, 1, 0, 0, 0},
        '{0, 0,  8, 1, 0, 1, 2, 256}
    };

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_family = 1'b0;
    logic [1:0] cfg_ratio = '0;
    logic [1:0] cfg_width = '0;
    logic [4:0] cfg_slots = '0;
    logic       cfg_tdm = 1'b0;
    logic       bclk, lrck, config_error;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int cur_r = 0, cur_d = 0, cur_tdm = 0;

    bit mon_en = 1'b0;
    int ok_a = 0, ok_b = 0;
    int run_len = 0;
    bit mon_pb = 1'b0;

    audio_sclk_gen dut_i (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_family   (cfg_family),
        .cfg_ratio    (cfg_ratio),
        .cfg_width    (cfg_width),
        .cfg_slots    (cfg_slots),
        .cfg_tdm      (cfg_tdm),
        .bclk         (bclk),
        .lrck         (lrck),
        .config_error (config_error)
    );

    always #(CLK_PERIOD/2) mclk = ~mclk;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge mclk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // R7: every bclk high phase must match the old or the new divider
    always @(negedge mclk) begin
        if (bclk) run_len++;
        else begin
            if (mon_pb && mon_en) begin
                n_chk++;
                if (run_len != ok_a && run_len != ok_b) begin
                    n_err++;
                    $display("FAIL R7 bclk high phase actual=%0d expected=%0d or %0d",
                             run_len, ok_a, ok_b);
                end
            end
            run_len = 0;
        end
        mon_pb = bclk;
    end

    task automatic drive_cfg(input int r, input int w, input int n, input int t, input int f);
        cfg_ratio  = 2'(r);
        cfg_width  = 2'(w);
        cfg_slots  = 5'(n);
        cfg_tdm    = 1'(t);
        cfg_family = 1'(f);
    endtask

    task automatic load(input int r, input int w, input int n, input int t, input int f);
        @(negedge mclk);
        drive_cfg(r, w, n, t, f);
        cfg_load = 1'b1;
        @(negedge mclk);
        cfg_load = 1'b0;
    endtask

    task automatic measure(input int win, output int b_r, output int b_h,
                           output int l_r, output int l_h, output int bad);
        bit pb, pl;
        b_r = 0; b_h = 0; l_r = 0; l_h = 0; bad = 0;
        @(negedge mclk);
        pb = bclk; pl = lrck;
        repeat (win) begin
            @(negedge mclk);
            if (bclk && !pb) b_r++;
            if (bclk) b_h++;
            if (lrck && !pl) l_r++;
            if (lrck) l_h++;
            if (lrck != pl && !(pb && !bclk)) bad++;
            pb = bclk; pl = lrck;
        end
    endtask

    task automatic check_clocks(input string tag);
        int b_r, b_h, l_r, l_h, bad;
        measure(2 * cur_r, b_r, b_h, l_r, l_h, bad);
        chk_eq({tag, " R2/R3 bclk rising edges in two frames"}, b_r, 2 * cur_r / cur_d);
        chk_eq({tag, " R2 bclk high samples"}, b_h, cur_r);
        chk_eq({tag, " R4 lrck rising edges in two frames"}, l_r, 2);
        if (cur_tdm != 0) begin
            chk_eq({tag, " R6 sync high samples"}, l_h, 2 * cur_d);
        end else begin
            chk_eq({tag, " R5 lrck high samples"}, l_h, cur_r);
        end
        chk_eq({tag, " R5/R6 lrck edges off bclk fall"}, bad, 0);
    endtask

    initial begin
        int k;
        bit seen;
        // R1: reset state
        repeat (5) @(negedge mclk);
        chk_eq("R1 bclk in reset", int'(bclk), 0);
        chk_eq("R1 lrck in reset", int'(lrck), 0);
        chk_eq("R1 error in reset", int'(config_error), 0);
        rst_n = 1'b1;
        repeat (40) @(negedge mclk);
        chk_eq("R1 bclk idle", int'(bclk), 0);
        chk_eq("R1 lrck idle", int'(lrck), 0);
        chk_eq("R1 error idle", int'(config_error), 0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            load(VEC[i].r, VEC[i].w, VEC[i].n, VEC[i].tdm, VEC[i].fam);
            repeat (1100) @(negedge mclk);
            chk_eq($sformatf("vec%0d R9 config_error", i), int'(config_error),
                   VEC[i].ok != 0 ? 0 : 1);
            if (VEC[i].ok != 0) begin
                cur_r = VEC[i].rlen; cur_d = VEC[i].d; cur_tdm = VEC[i].tdm;
            end
            check_clocks($sformatf("vec%0d", i));
        end

        // R7: switch from divide-by-2 multi-slot to divide-by-8 stereo
        ok_a = 1; ok_b = 4; mon_en = 1'b1;
        load(2, 2, 2, 0, 1);
        repeat (1100) @(negedge mclk);
        cur_r = 512; cur_d = 8; cur_tdm = 0;
        check_clocks("switch1 R7");

        // R7: request at mid-frame lrck rise, expect quiet until frame end
        ok_a = 4; ok_b = 2;
        seen = 1'b0;
        @(negedge mclk);
        while (!seen) begin
            bit pl;
            pl = lrck;
            @(negedge mclk);
            if (lrck && !pl) seen = 1'b1;
        end
        drive_cfg(2, 2, 4, 1, 1);
        cfg_load = 1'b1;
        k = 0;
        seen = 1'b0;
        while (!seen && k < 2000) begin
            @(negedge mclk);
            cfg_load = 1'b0;
            k++;
            if (k > 10 && (bclk || lrck)) seen = 1'b1;
        end
        chk_eq("R7 quiet gap to frame start", k, 256);
        chk_eq("R7 new frame opens with sync high", int'(lrck), 1);
        chk_eq("R7 new frame opens with bclk low", int'(bclk), 0);
        repeat (600) @(negedge mclk);
        cur_r = 512; cur_d = 4; cur_tdm = 1;
        check_clocks("switch2 R7");
        mon_en = 1'b0;

        // R8: identical reload leaves clocks running
        @(negedge mclk);
        drive_cfg(2, 2, 4, 1, 1);
        cfg_load = 1'b1;
        begin
            int b_r, b_h, l_r, l_h, bad;
            measure(1024, b_r, b_h, l_r, l_h, bad);
            chk_eq("R8 bclk edges across identical reload", b_r, 256);
            chk_eq("R8 bclk high across identical reload", b_h, 512);
            chk_eq("R8 lrck edges across identical reload", l_r, 2);
        end
        cfg_load = 1'b0;
        chk_eq("R8 error stays clear", int'(config_error), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // keep the strobe one cycle wide in the R8 step
    always @(negedge mclk) begin
        if (cfg_load && cyc > 2) begin
            @(negedge mclk);
            cfg_load = 1'b0;
        end
    end

endmodule